// File: doc/BRIEF.md
# Cycle-Driven Interrupt Down-Counter

This block is a 16-bit down-counter that advances once per processor clock and raises a level interrupt request when it runs out. Software loads it one byte at a time through two write strobes that an outside decoder produces, and both strobes share one 8-bit data bus. Loading the upper byte also decides whether the counter runs. That decision copies a single permission bit, which is kept in a mode register elsewhere and is presented here as one input.

When a decrement lands on zero, three things happen together: the counter stops itself, it refills with all ones, and the interrupt line goes high. The line stays high until software writes the lower byte again, and that write is the acknowledge. A write to the upper byte does not clear the line. In the same cycle, a byte write wins over the decrement.

Top module: `cycle_irq_timer`

## Requirements
- R1: After reset the counter is 0, counting is stopped and `irq` is 0.
- R2: A `wr_lo` write puts `wr_data` into counter bits 7:0 and drives `irq` to 0 from the next cycle.
- R3: A `wr_hi` write puts `wr_data` into counter bits 15:8 and sets the run flag equal to `arm_permit`.
- R4: While the run flag is set and no write happens, the counter drops by one on every clock, so a counter armed at value V (V > 0) raises `irq` V clocks after the arming write.
- R5: When a decrement gives zero, the run flag clears, the counter reloads 0xFFFF and `irq` rises. Re-arming with only the upper byte written as 0xFF then takes 65535 clocks.
- R6: `irq` stays high until a `wr_lo` write, and a `wr_hi` write leaves it high.
- R7: A counter armed with value 0 wraps to 0xFFFF and fires after 65536 clocks.
- R8: While the run flag is clear, the counter keeps its value.
- R9: A byte write in a cycle where the counter would decrement replaces the byte, and no decrement happens in that cycle.
- R10: A `wr_hi` write with `arm_permit` = 0 stops a running counter, and no `irq` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; one count per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Write strobe for counter bits 7:0; also the acknowledge |
| wr_hi | input | 1 | Write strobe for counter bits 15:8; also arms or stops |
| wr_data | input | 8 | Byte written by either strobe |
| arm_permit | input | 1 | Permission bit from the mode register; copied into the run flag on `wr_hi` |
| irq | output | 1 | Level interrupt request |

## Verification
The counter is armed at several values: zero (a full wrap), small values (exact firing latency), and the all-ones reload left behind by an expiry. Together these separate an off-by-one in the zero detect from a wrong reload value. Further stimulus writes the lower byte while the counter runs, which shows that the write wins over the decrement. It also writes the upper byte with permission cleared, both during a count and while `irq` is high, which separates stopping from acknowledging. Hold periods are placed between stopping and re-arming. The firing latency after re-arming then shows whether the counter kept its value.

// File: rtl/irq_ctr_pkg.sv
package irq_ctr_pkg;

    // What the counter register does in the current cycle
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_DEC    = 2'd2,
        ACT_EXPIRE = 2'd3
    } ctr_act_e;

endpackage

// File: rtl/irq_ctr_ctl.sv
module irq_ctr_ctl
    import irq_ctr_pkg::*;
#(
    parameter int NLANES = 2
) (
    input  logic [NLANES-1:0] lane_wr,
    input  logic              run_q,
    input  logic              cnt_is_one,
    output ctr_act_e          act
);

    always_comb begin
        if (|lane_wr) begin
            act = ACT_LOAD;            // writes win over counting
        end else if (run_q) begin
            act = cnt_is_one ? ACT_EXPIRE : ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/irq_ctr_datapath.sv
module irq_ctr_datapath
    import irq_ctr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NLANES = 2,
    localparam int CNT_W = DATA_W * NLANES
) (
    input  ctr_act_e          act,
    input  logic [NLANES-1:0] lane_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d,
    output logic              cnt_is_one
);

    logic [CNT_W-1:0] loaded;

    // One byte lane per strobe; unwritten lanes keep their value
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign loaded[g*DATA_W +: DATA_W] =
            lane_wr[g] ? wr_data : cnt_q[g*DATA_W +: DATA_W];
    end

    assign cnt_is_one = (cnt_q == CNT_W'(1));

    always_comb begin
        case (act)
            ACT_LOAD:   cnt_d = loaded;
            ACT_DEC:    cnt_d = cnt_q - CNT_W'(1);
            ACT_EXPIRE: cnt_d = '1;
            default:    cnt_d = cnt_q;
        endcase
    end

endmodule

// File: rtl/cycle_irq_timer.sv
module cycle_irq_timer
    import irq_ctr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NLANES = 2,
    localparam int CNT_W = DATA_W * NLANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arm_permit,
    output logic              irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             irq;
    } state_t;

    state_t            state_d, state_q;
    ctr_act_e          act;
    logic [NLANES-1:0] lane_wr;
    logic [CNT_W-1:0]  cnt_nx;
    logic              cnt_is_one;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;

    assign lane_wr = {wr_hi, wr_lo};
    assign cnt_q   = state_q.cnt;
    assign run_q   = state_q.run;

    irq_ctr_ctl #(.NLANES(NLANES)) u_ctl (
        .lane_wr    (lane_wr),
        .run_q      (run_q),
        .cnt_is_one (cnt_is_one),
        .act        (act)
    );

    irq_ctr_datapath #(.DATA_W(DATA_W), .NLANES(NLANES)) u_dp (
        .act        (act),
        .lane_wr    (lane_wr),
        .wr_data    (wr_data),
        .cnt_q      (cnt_q),
        .cnt_d      (cnt_nx),
        .cnt_is_one (cnt_is_one)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_nx;
        case (act)
            ACT_LOAD: begin
                if (wr_hi) state_d.run = arm_permit;
                if (wr_lo) state_d.irq = 1'b0;
            end
            ACT_EXPIRE: begin
                state_d.run = 1'b0;
                state_d.irq = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq = state_q.irq;

endmodule

// File: rtl/irq_ctr_chk.sv
module irq_ctr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic             arm_permit,
    input logic [CNT_W-1:0] cnt_q,
    input logic             run_q,
    input logic             irq
);

    assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !irq);

    assert_run_follows_permit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (run_q == $past(arm_permit)));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wr_lo && !wr_hi && cnt_q != CNT_W'(1))
            |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

    assert_expiry_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt_q == '1 && !run_q));

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_lo) |=> irq);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_lo && !wr_hi) |=> $stable(cnt_q));

endmodule

bind cycle_irq_timer irq_ctr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .arm_permit (arm_permit),
    .cnt_q      (cnt_q),
    .run_q      (run_q),
    .irq        (irq)
);

// File: tb/tb_cycle_irq_timer.sv
module tb_cycle_irq_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       arm_permit = 1'b0;
    logic       irq;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0;
    bit m_run = 0;
    bit m_irq = 0;

    always #5 clk = ~clk;

    cycle_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .arm_permit(arm_permit), .irq(irq)
    );

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_irq = 0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) begin m_cnt = (m_cnt / 256) * 256 + wr_data; m_irq = 0; end
            if (wr_hi) begin m_cnt = (m_cnt % 256) + wr_data * 256; m_run = arm_permit; end
        end else if (m_run) begin
            m_cnt = (m_cnt + 65535) % 65536;
            if (m_cnt == 0) begin m_run = 0; m_cnt = 65535; m_irq = 1; end
        end
    end

    // Compare against the reference every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (irq !== m_irq) begin
                bad++;
                $display("FAIL %s model: irq=%0b expected=%0b", tag, irq, m_irq);
            end
        end
    end

    task automatic check(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic wr(input bit lo, input bit hi, input logic [7:0] d, input bit p);
        @(negedge clk);
        wr_lo = lo; wr_hi = hi; wr_data = d; arm_permit = p;
        @(negedge clk);
        wr_lo = 0; wr_hi = 0;
    endtask

    // Clocks from the write edge until irq is seen (limit if never)
    task automatic wait_fire(input int limit, output int n);
        n = 0;
        while (n < limit && irq !== 1'b1) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        check("R1 irq after reset", irq, 0);

        // R1 + R7: arm straight from reset (counter 0) -> full wrap
        tag = "R7";
        wr(0, 1, 8'h00, 1);
        wait_fire(70000, n);
        check("R7/R1 zero arm fires after 65536", n, 65536);

        // R2: acknowledge
        tag = "R2";
        wr(1, 0, 8'h05, 0);
        check("R2 low write clears irq", irq, 0);

        // R4: small count
        tag = "R4";
        wr(0, 1, 8'h00, 1);
        wait_fire(100, n);
        check("R4 count of 5", n, 5);

        // R6: stays high, hi write does not clear
        tag = "R6";
        idle(20);
        check("R6 irq held", irq, 1);
        wr(0, 1, 8'h12, 0);
        idle(3);
        check("R6 hi write keeps irq", irq, 1);
        tag = "R2";
        wr(1, 0, 8'h03, 0);
        check("R2 ack after hi write", irq, 0);

        // R8: counter 0x1203 stopped; hold then re-arm with hi = 0
        tag = "R8";
        idle(15);
        check("R8 no irq while stopped", irq, 0);
        tag = "R3";
        wr(0, 1, 8'h00, 1);
        wait_fire(100, n);
        check("R3/R8 held low byte gives 3", n, 3);
        wr(1, 0, 8'h00, 0);

        // R9: reload low byte while running
        tag = "R9";
        wr(1, 0, 8'h10, 0);
        wr(0, 1, 8'h00, 1);
        idle(3);
        wr(1, 0, 8'h08, 0);
        wait_fire(100, n);
        check("R9 write replaces count, no decrement", n, 8);
        wr(1, 0, 8'h00, 0);

        // R10: stop a running count
        tag = "R10";
        wr(1, 0, 8'h20, 0);
        wr(0, 1, 8'h00, 1);
        idle(2);
        wr(0, 1, 8'h00, 0);
        idle(40);
        check("R10 stopped counter gives no irq", irq, 0);
        wr(0, 1, 8'h00, 1);
        wait_fire(100, n);
        check("R10 resume from held 29", n, 29);

        // R5: reload value after expiry is 0xFFFF
        tag = "R5";
        wr(1, 0, 8'hFF, 0);
        check("R5 ack before reload test", irq, 0);
        wr(0, 1, 8'hFF, 1);
        wait_fire(70000, n);
        check("R5 reload 0xFFFF counts 65535", n, 65535);

        idle(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule